// File: doc/BRIEF.md
# Two-Stage Compare Watchdog Timer

This block is a memory-mapped watchdog that needs no counter of its own. The system supplies a free-running 64-bit time base. The block stores an absolute 64-bit deadline and compares the time base against it on every clock.

When the deadline first passes, the block raises an interrupt (stage 0) and arms a new deadline one timeout period later. If software has still not serviced the watchdog when that second deadline passes, the block raises a reset request (stage 1). The system reset logic uses that request to force a hardware reset. The gap between the two stages gives a handler or a debug agent a chance to recover, or to collect crash state, before the system is reset.

Software reaches two register windows through one simple 32-bit port. A frame-select bit picks the window:
- The control window holds the enable and status bits, the timeout length and the current deadline.
- The service window holds the register that software writes to restart the timeout.
- Both windows hold read-only identification words.

Read data comes from a register and appears one clock after the request.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset every register is zero, so the watchdog is disabled, both outputs are low and the control/status word (control frame, offset 0x000) reads 0.
- R2: Bit 0 of a write to the control/status word sets the enable state, and bit 0 of a read returns it.
- R3: A write to the control/status word, a write to the service register (service frame, offset 0x000), or a write to the timeout register each do the same three things in the same clock. They load the deadline with the time base plus the timeout zero-extended to 64 bits, using the new timeout if that write changes it. They clear both stage flags.
- R4: The 32-bit timeout length in ticks is read and written at control-frame offset 0x008.
- R5: The deadline reads back at control-frame offset 0x010 (bits 31:0) and 0x014 (bits 63:32), with a carry from the low half into the high half.
- R6: While enabled with stage 0 clear, a time base greater than or equal to the deadline sets stage 0, drives `irq_stage0` high, and reloads the deadline with the time base plus the timeout.
- R7: While enabled with stage 0 set, a time base at or past the deadline sets stage 1 and drives `reset_req` high. The deadline is not reloaded. Stage 1 and stage 0 stay set until the next event listed in R3.
- R8: The control/status word returns stage 0 in bit 1 and stage 1 in bit 2.
- R9: While disabled, no expiry is evaluated and both outputs stay low, whatever the time base is.
- R10: Offset 0xFCC of either frame reads the identification word:
  - bits 19:16 are the architecture version, 0;
  - bits 15:12 are parameter `REVISION`;
  - bits 11:8 are bits 10:7 of parameter `IMPL_CODE`;
  - bits 6:0 are bits 6:0 of `IMPL_CODE`;
  - all other bits are 0.
- R11: Offset 0xFE8 of either frame reads parameter `PERIPH_ID2`.
- R12: Reads from any offset not listed above return 0, including the service register itself. Writes to such offsets change no state and start no reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_cnt | input | 64 | Free-running system time base |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_frame | input | 1 | 0 selects the control frame, 1 the service frame |
| req_addr | input | 12 | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| irq_stage0 | output | 1 | Stage-0 interrupt |
| reset_req | output | 1 | Stage-1 reset request |

## Verification
- Writes and expiries take effect at the clock edge that samples them, and both outputs come straight from state flops. The bench therefore sets the time base or a request on the falling edge and checks the outputs on the falling edge one cycle later.
- Read data is registered and shows the state as it was before the sampling edge. Each read is checked at the falling edge that follows its request.
- The time base is held constant while a write is pending, so every expected deadline is an exact sum the bench can form from its own values.
- Expiry cases set the time base one tick below the deadline and then exactly on it, to pin down the greater-or-equal comparison.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h000;
    localparam logic [ADDR_W-1:0] A_TMO     = 12'h008;
    localparam logic [ADDR_W-1:0] A_DL_LO   = 12'h010;
    localparam logic [ADDR_W-1:0] A_DL_HI   = 12'h014;
    localparam logic [ADDR_W-1:0] A_SERVICE = 12'h000;
    localparam logic [ADDR_W-1:0] A_IDENT   = 12'hFCC;
    localparam logic [ADDR_W-1:0] A_PID2    = 12'hFE8;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_TMO,
        RS_DL_LO,
        RS_DL_HI,
        RS_IDENT,
        RS_PID2
    } rsel_e;

    typedef struct packed {
        logic              en;
        logic              s0;
        logic              s1;
        logic [DATA_W-1:0] tmo;
        logic [CNT_W-1:0]  dl;
    } core_st_t;

endpackage

// File: rtl/wdog_addr_dec.sv
module wdog_addr_dec
    import wdog_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_frame,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              wr_ctrl,
    output logic              wr_tmo,
    output logic              wr_service,
    output rsel_e             rsel
);

    logic wr_go;
    logic rd_go;

    always_comb begin
        wr_go      = req_valid && req_write;
        rd_go      = req_valid && !req_write;
        wr_ctrl    = wr_go && !req_frame && (req_addr == A_CTRL);
        wr_tmo     = wr_go && !req_frame && (req_addr == A_TMO);
        wr_service = wr_go &&  req_frame && (req_addr == A_SERVICE);

        rsel = RS_NONE;
        if (rd_go) begin
            if (req_addr == A_IDENT) begin
                rsel = RS_IDENT;
            end else if (req_addr == A_PID2) begin
                rsel = RS_PID2;
            end else if (!req_frame) begin
                case (req_addr)
                    A_CTRL:  rsel = RS_CTRL;
                    A_TMO:   rsel = RS_TMO;
                    A_DL_LO: rsel = RS_DL_LO;
                    A_DL_HI: rsel = RS_DL_HI;
                    default: rsel = RS_NONE;
                endcase
            end
        end
    end

    // Only one write strobe can be active at a time.
    always_comb begin
        AST_ONE_WRITE_STROBE: assert ($onehot0({wr_ctrl, wr_tmo, wr_service})); // R3
    end

endmodule

// File: rtl/wdog_cmp_core.sv
module wdog_cmp_core
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              wr_ctrl,
    input  logic              wr_tmo,
    input  logic              wr_service,
    input  logic [DATA_W-1:0] wdata,
    output core_st_t          st
);

    core_st_t st_d;
    core_st_t st_q;
    logic     reload;
    logic     expired;

    always_comb begin
        st_d    = st_q;
        reload  = wr_ctrl || wr_tmo || wr_service;
        expired = (sys_cnt >= st_q.dl);

        if (wr_tmo) begin
            st_d.tmo = wdata;
        end
        if (wr_ctrl) begin
            st_d.en = wdata[0];
        end

        if (reload) begin
            // Uses the new timeout when this same write changes it.
            st_d.dl = sys_cnt + CNT_W'(st_d.tmo);
            st_d.s0 = 1'b0;
            st_d.s1 = 1'b0;
        end else if (st_q.en && expired) begin
            if (!st_q.s0) begin
                st_d.s0 = 1'b1;
                st_d.dl = sys_cnt + CNT_W'(st_q.tmo);
            end else begin
                st_d.s1 = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    AST_RELOAD_CLEARS_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (!st_q.s0 && !st_q.s1)); // R3

    AST_RELOAD_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.dl == $past(sys_cnt) + CNT_W'(st_q.tmo))); // R3

    AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !st_q.s0 && !reload && expired) |=> st_q.s0); // R6

    AST_STAGE1_AFTER_STAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1 |-> st_q.s0); // R7

    AST_STAGE1_KEEPS_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1 && !reload) |=> $stable(st_q.dl)); // R7

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> (!st_q.s0 && !st_q.s1)); // R9

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
    import wdog_pkg::*;
#(
    parameter logic [3:0]        REVISION   = 4'h3,
    parameter logic [10:0]       IMPL_CODE  = 11'h43B,
    parameter logic [DATA_W-1:0] PERIPH_ID2 = 32'h0000_000B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_frame,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_stage0,
    output logic              reset_req
);

    localparam logic [3:0]        ARCH_VER   = 4'h0;
    localparam logic [DATA_W-1:0] IDENT_WORD = {12'h000, ARCH_VER, REVISION,
                                                IMPL_CODE[10:7], 1'b0, IMPL_CODE[6:0]};

    logic              wr_ctrl;
    logic              wr_tmo;
    logic              wr_service;
    rsel_e             rsel;
    core_st_t          st;
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rd_q;

    wdog_addr_dec u_dec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_frame  (req_frame),
        .req_addr   (req_addr),
        .wr_ctrl    (wr_ctrl),
        .wr_tmo     (wr_tmo),
        .wr_service (wr_service),
        .rsel       (rsel)
    );

    wdog_cmp_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_cnt    (sys_cnt),
        .wr_ctrl    (wr_ctrl),
        .wr_tmo     (wr_tmo),
        .wr_service (wr_service),
        .wdata      (req_wdata),
        .st         (st)
    );

    always_comb begin
        rd_d = rd_q;
        if (req_valid && !req_write) begin
            case (rsel)
                RS_CTRL:  rd_d = {{(DATA_W-3){1'b0}}, st.s1, st.s0, st.en};
                RS_TMO:   rd_d = st.tmo;
                RS_DL_LO: rd_d = st.dl[DATA_W-1:0];
                RS_DL_HI: rd_d = st.dl[CNT_W-1:DATA_W];
                RS_IDENT: rd_d = IDENT_WORD;
                RS_PID2:  rd_d = PERIPH_ID2;
                default:  rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data    = rd_q;
    assign irq_stage0 = st.en && st.s0;
    assign reset_req  = st.en && st.s1;

    AST_RESET_REQ_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> irq_stage0); // R7

    AST_IDENT_ARCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == A_IDENT) |=> (rd_data[19:16] == 4'h0)); // R10

endmodule

// File: tb/test_dual_stage_wdog.sv
module test_dual_stage_wdog;

    localparam logic [3:0]  REV  = 4'h3;
    localparam logic [10:0] IMPL = 11'h43B;
    localparam logic [31:0] PID2 = 32'h0000_000B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_cnt = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_frame = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        irq_stage0;
    logic        reset_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dual_stage_wdog #(.REVISION(REV), .IMPL_CODE(IMPL), .PERIPH_ID2(PID2)) i_dual_stage_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_cnt    (sys_cnt),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_frame  (req_frame),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_data    (rd_data),
        .irq_stage0 (irq_stage0),
        .reset_req  (reset_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic frame, input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_frame = frame;
        req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic frame, input logic [11:0] addr, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_frame = frame; req_addr = addr;
        @(negedge clk);
        data = rd_data;
        req_valid = 1'b0;
    endtask

    task automatic set_cnt(input logic [63:0] v, input int cycles);
        @(negedge clk);
        sys_cnt = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic read_deadline(output logic [63:0] dl);
        logic [31:0] lo;
        logic [31:0] hi;
        rd(1'b0, 12'h010, lo);
        rd(1'b0, 12'h014, hi);
        dl = {hi, lo};
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq after reset", 64'(irq_stage0), 0);
        chk("R1 reset_req after reset", 64'(reset_req), 0);
        rd(1'b0, 12'h000, v);
        chk("R1 ctrl word after reset", 64'(v), 0);
        rd(1'b0, 12'h008, v);
        chk("R1 timeout after reset", 64'(v), 0);
    endtask

    task automatic t_timeout_reload;
        logic [31:0] v;
        logic [63:0] dl;
        set_cnt(64'd1000, 0);
        wr(1'b0, 12'h008, 32'd100);
        rd(1'b0, 12'h008, v);
        chk("R4 timeout readback", 64'(v), 100);
        read_deadline(dl);
        chk("R3 R5 deadline after timeout write", dl, 64'd1100);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        set_cnt(64'd5000, 3);
        chk("R9 irq while disabled", 64'(irq_stage0), 0);
        chk("R9 reset_req while disabled", 64'(reset_req), 0);
        rd(1'b0, 12'h000, v);
        chk("R9 R8 status while disabled", 64'(v), 0);
    endtask

    task automatic t_two_stages;
        logic [31:0] v;
        logic [63:0] dl;
        set_cnt(64'd2000, 0);
        wr(1'b0, 12'h000, 32'h1);
        rd(1'b0, 12'h000, v);
        chk("R2 enable readback", 64'(v), 1);
        read_deadline(dl);
        chk("R3 deadline on enable", dl, 64'd2100);
        set_cnt(64'd2099, 2);
        chk("R6 no irq one tick early", 64'(irq_stage0), 0);
        set_cnt(64'd2100, 1);
        chk("R6 irq at deadline", 64'(irq_stage0), 1);
        chk("R7 no reset_req yet", 64'(reset_req), 0);
        rd(1'b0, 12'h000, v);
        chk("R8 status stage0", 64'(v), 3);
        read_deadline(dl);
        chk("R6 deadline rearmed", dl, 64'd2200);
        set_cnt(64'd2199, 2);
        chk("R7 no reset_req one tick early", 64'(reset_req), 0);
        set_cnt(64'd2200, 1);
        chk("R7 reset_req at second deadline", 64'(reset_req), 1);
        set_cnt(64'd2500, 3);
        chk("R7 reset_req held", 64'(reset_req), 1);
        rd(1'b0, 12'h000, v);
        chk("R8 status stage1", 64'(v), 7);
        read_deadline(dl);
        chk("R7 deadline not reloaded", dl, 64'd2200);
    endtask

    task automatic t_service;
        logic [31:0] v;
        logic [63:0] dl;
        set_cnt(64'd3000, 0);
        wr(1'b1, 12'h000, 32'hDEAD_BEEF);
        chk("R3 service clears irq", 64'(irq_stage0), 0);
        chk("R3 service clears reset_req", 64'(reset_req), 0);
        read_deadline(dl);
        chk("R3 deadline after service", dl, 64'd3100);
        rd(1'b1, 12'h000, v);
        chk("R12 service register reads zero", 64'(v), 0);
        set_cnt(64'd3150, 1);
        chk("R6 irq after service period", 64'(irq_stage0), 1);
        wr(1'b0, 12'h000, 32'h0);
        chk("R2 disable drops irq", 64'(irq_stage0), 0);
        rd(1'b0, 12'h000, v);
        chk("R2 disabled status", 64'(v), 0);
    endtask

    task automatic t_carry;
        logic [63:0] dl;
        set_cnt(64'h0000_0001_FFFF_FFF0, 0);
        wr(1'b0, 12'h008, 32'h20);
        read_deadline(dl);
        chk("R5 deadline carry into high word", dl, 64'h0000_0002_0000_0010);
    endtask

    task automatic t_ident;
        logic [31:0] v;
        logic [31:0] exp_id;
        exp_id = (32'(REV) << 12) | (32'(IMPL >> 7) << 8) | 32'(IMPL & 11'h07F);
        rd(1'b0, 12'hFCC, v);
        chk("R10 ident control frame", 64'(v), 64'(exp_id));
        rd(1'b1, 12'hFCC, v);
        chk("R10 ident service frame", 64'(v), 64'(exp_id));
        rd(1'b0, 12'hFE8, v);
        chk("R11 id2 control frame", 64'(v), 64'(PID2));
        rd(1'b1, 12'hFE8, v);
        chk("R11 id2 service frame", 64'(v), 64'(PID2));
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        logic [63:0] dl;
        rd(1'b0, 12'h004, v);
        chk("R12 unmapped control read", 64'(v), 0);
        rd(1'b1, 12'h008, v);
        chk("R12 unmapped service read", 64'(v), 0);
        set_cnt(64'd9000, 0);
        wr(1'b0, 12'h004, 32'hFFFF_FFFF);
        wr(1'b1, 12'h004, 32'hFFFF_FFFF);
        wr(1'b0, 12'hFCC, 32'hFFFF_FFFF);
        rd(1'b0, 12'h000, v);
        chk("R12 unmapped write leaves ctrl", 64'(v), 0);
        rd(1'b0, 12'h008, v);
        chk("R12 unmapped write leaves timeout", 64'(v), 64'h20);
        read_deadline(dl);
        chk("R12 unmapped write starts no reload", dl, 64'h0000_0002_0000_0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timeout_reload();
        t_disabled();
        t_two_stages();
        t_service();
        t_carry();
        t_ident();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule